// File: doc/BRIEF.md
# 100 Mb/s Receive Code-Group Decoder

This block takes aligned 5-bit code-groups from a descrambled 100 Mb/s receive path, one per enabled clock, and turns them into the nibble-wide receive interface a MAC expects: a data nibble, a valid-data flag and an error flag. It searches for the two-group start-of-stream delimiter (/J/ then /K/), decodes the sixteen 4B5B data groups into nibbles while a frame is open, and closes the frame on the /T/ then /R/ end-of-stream pair. Any other group inside a frame is reported as a receive error.

A start-of-stream delimiter that breaks after /J/ is reported on its own terms: the error flag rises and the nibble is forced to 4'b1110, while valid-data stays low. The block then goes back to hunting for /J/. It runs in one domain. A clock enable (`cg_en`) marks the 25 MHz code-group slots on a faster clock, and all outputs are registered on enabled edges.

Top module: `pcs100_rx_decode`

## Requirements
- R1: While reset is held and right after it is released, `rxd` is 4'b0000 and `rx_dv` and `rx_er` are both low.
- R2: The group /J/ (5'b11000) seen while hunting, and the /K/ (5'b10001) right after it, are each output as the nibble 4'b0101 with `rx_dv` low and `rx_er` low.
- R3: After a correct /J/K/, each data group produces its nibble with `rx_dv` high and `rx_er` low. The mapping is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: Inside a frame, /T/ (5'b01101) followed by /R/ (5'b00111) gives `rx_dv` low and `rx_er` low on both slots, and the block goes back to hunting.
- R5: A /J/ followed by any group other than /K/ gives one slot with `rxd` = 4'b1110, `rx_er` high and `rx_dv` low. The block then hunts again, with outputs 0/0/0 for Idle.
- R6: Inside a frame, a group that is neither data, /T/ nor Idle raises `rx_er` for that slot while `rx_dv` stays high, and the frame continues.
- R7: Idle (5'b11111) inside a frame gives one slot with `rx_er` high and `rx_dv` low. The frame is over, and data groups that follow give `rx_dv` low.
- R8: When `cg_en` is low, `rxd`, `rx_dv` and `rx_er` hold their values whatever `cg_in` carries.
- R9: A /T/ inside a frame followed by anything but /R/ gives `rx_er` high with `rx_dv` low on the second slot, and the block goes back to hunting.
- R10: While hunting, data groups and /K/ are ignored: outputs stay 4'b0000, low, low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cg_en | input | 1 | High on the clock that carries a new code-group slot |
| cg_in | input | 5 | Aligned, descrambled code-group |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
Each result is due exactly one register stage after its code-group is taken: a group presented with `cg_en` high is captured on that rising edge, and the matching outputs are valid from then until the next enabled edge. The bench drives the group and the enable on a falling edge, lets one rising edge pass, then samples on the next falling edge and drops the enable. Every comparison therefore falls in the slot of the group it checks. For the hold behaviour, the bench also drives garbage with the enable low for several clocks and checks that the outputs have not moved. Multi-slot outcomes are checked one slot at a time: bad start, mid-frame Idle and a broken end pair each get an error slot, then a following slot that must show the return to hunting.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

  localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_BAD_SSD  = 4'b1110;

  typedef enum logic [2:0] {
    CK_DATA, CK_J, CK_K, CK_T, CK_R, CK_IDLE, CK_BAD
  } cg_kind_e;

  typedef enum logic [1:0] {
    ST_HUNT, ST_SAW_J, ST_FRAME, ST_SAW_T
  } rx_state_e;
endpackage

// File: rtl/pcs_rx_rst_sync.sv
module pcs_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcs_rx_cg_classify.sv
module pcs_rx_cg_classify
  import pcs_rx_pkg::*;
(
  input  logic [CG_W-1:0]  cg,
  output cg_kind_e         kind,
  output logic [NIB_W-1:0] nibble
);
  always_comb begin
    kind   = CK_DATA;
    nibble = '0;
    unique case (cg)
      5'b11110: nibble = 4'h0;
      5'b01001: nibble = 4'h1;
      5'b10100: nibble = 4'h2;
      5'b10101: nibble = 4'h3;
      5'b01010: nibble = 4'h4;
      5'b01011: nibble = 4'h5;
      5'b01110: nibble = 4'h6;
      5'b01111: nibble = 4'h7;
      5'b10010: nibble = 4'h8;
      5'b10011: nibble = 4'h9;
      5'b10110: nibble = 4'hA;
      5'b10111: nibble = 4'hB;
      5'b11010: nibble = 4'hC;
      5'b11011: nibble = 4'hD;
      5'b11100: nibble = 4'hE;
      5'b11101: nibble = 4'hF;
      CG_J:     kind = CK_J;
      CG_K:     kind = CK_K;
      CG_T:     kind = CK_T;
      CG_R:     kind = CK_R;
      CG_IDLE:  kind = CK_IDLE;
      default:  kind = CK_BAD;
    endcase
  end
endmodule

// File: rtl/pcs_rx_frame_fsm.sv
module pcs_rx_frame_fsm
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cg_kind_e         kind,
  input  logic [NIB_W-1:0] nibble,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er
);
  rx_state_e        state_q, state_d;
  logic [NIB_W-1:0] rxd_q, rxd_d;
  logic             dv_q, dv_d, er_q, er_d;

  always_comb begin
    state_d = state_q;
    rxd_d   = '0;
    dv_d    = 1'b0;
    er_d    = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (kind == CK_J) begin
          state_d = ST_SAW_J;
          rxd_d   = NIB_PREAMBLE;
        end
      end
      ST_SAW_J: begin
        if (kind == CK_K) begin
          state_d = ST_FRAME;
          rxd_d   = NIB_PREAMBLE;
        end else begin
          state_d = ST_HUNT;
          rxd_d   = NIB_BAD_SSD;
          er_d    = 1'b1;
        end
      end
      ST_FRAME: begin
        unique case (kind)
          CK_DATA: begin
            rxd_d = nibble;
            dv_d  = 1'b1;
          end
          CK_T:    state_d = ST_SAW_T;
          CK_IDLE: begin
            state_d = ST_HUNT;
            er_d    = 1'b1;
          end
          default: begin
            dv_d = 1'b1;
            er_d = 1'b1;
          end
        endcase
      end
      ST_SAW_T: begin
        state_d = ST_HUNT;
        er_d    = (kind != CK_R);
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      rxd_q   <= '0;
      dv_q    <= 1'b0;
      er_q    <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      rxd_q   <= rxd_d;
      dv_q    <= dv_d;
      er_q    <= er_d;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign rx_er = er_q;
endmodule

// File: rtl/pcs100_rx_decode.sv
module pcs100_rx_decode
  import pcs_rx_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_en,
  input  logic [CG_W-1:0]  cg_in,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er
);
  logic             rst_n_core;
  cg_kind_e         cg_kind;
  logic [NIB_W-1:0] cg_nibble;

  pcs_rx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  pcs_rx_cg_classify u_cls (
    .cg     (cg_in),
    .kind   (cg_kind),
    .nibble (cg_nibble)
  );

  pcs_rx_frame_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_core),
    .en     (cg_en),
    .kind   (cg_kind),
    .nibble (cg_nibble),
    .rxd    (rxd),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er)
  );
endmodule

// File: rtl/pcs100_rx_decode_chk.sv
module pcs100_rx_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cg_en,
  input logic [4:0] cg_in,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (rxd == 4'b0000 && !rx_dv && !rx_er));

  assert_preamble_before_dv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> $past(rxd) == 4'b0101);

  assert_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_en && rx_dv && cg_in == 5'b11110) |=> (rx_dv && !rx_er && rxd == 4'h0));

  assert_bad_ssd_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv && rxd != 4'b0000) |-> rxd == 4'b1110);

  assert_idle_midframe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_en && rx_dv && cg_in == 5'b11111) |=> (rx_er && !rx_dv));

  assert_hold_when_idle_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_en |=> $stable({rxd, rx_dv, rx_er}));
endmodule

bind pcs100_rx_decode pcs100_rx_decode_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cg_en (cg_en),
  .cg_in (cg_in),
  .rxd   (rxd),
  .rx_dv (rx_dv),
  .rx_er (rx_er)
);

// File: tb/pcs100_rx_decode_tb.sv
module pcs100_rx_decode_tb;
  logic       clk;
  logic       rst_n;
  logic       cg_en;
  logic [4:0] cg_in;
  logic [3:0] rxd;
  logic       rx_dv;
  logic       rx_er;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111, H = 5'b00100;

  pcs100_rx_decode u_dut (
    .clk(clk), .rst_n(rst_n), .cg_en(cg_en), .cg_in(cg_in),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic expect_out(input string req, input logic [3:0] e_rxd,
                            input logic e_dv, input logic e_er);
    n_checks++;
    if (rxd !== e_rxd || rx_dv !== e_dv || rx_er !== e_er) begin
      n_fail++;
      $display("FAIL %s: rxd/dv/er actual %h/%b/%b expected %h/%b/%b",
               req, rxd, rx_dv, rx_er, e_rxd, e_dv, e_er);
    end
  endtask

  // One code-group slot: driven on a falling edge, captured on the next
  // rising edge, outputs sampled on the falling edge after that.
  task automatic send(input logic [4:0] cg);
    cg_in = cg;
    cg_en = 1'b1;
    @(negedge clk);
    cg_en = 1'b0;
  endtask

  task automatic open_frame();
    send(J); send(K);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cg_en = 1'b0; cg_in = I;
    repeat (3) @(negedge clk);
    expect_out("R1 during reset", 4'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R1 after release", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_hunt_ignore();
    send(enc(4'h7)); expect_out("R10 data while hunting", 4'h0, 1'b0, 1'b0);
    send(K);         expect_out("R10 K while hunting", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_good_frame();
    send(J); expect_out("R2 J preamble", 4'b0101, 1'b0, 1'b0);
    send(K); expect_out("R2 K preamble", 4'b0101, 1'b0, 1'b0);
    for (int n = 0; n < 16; n++) begin
      send(enc(4'(n)));
      expect_out("R3 data nibble", 4'(n), 1'b1, 1'b0);
    end
    send(T); expect_out("R4 T slot", 4'h0, 1'b0, 1'b0);
    send(R); expect_out("R4 R slot", 4'h0, 1'b0, 1'b0);
    send(enc(4'h3)); expect_out("R4 back to hunting", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_bad_ssd();
    send(J); send(I);
    expect_out("R5 bad start slot", 4'b1110, 1'b0, 1'b1);
    send(I);
    expect_out("R5 idle after bad start", 4'h0, 1'b0, 1'b0);
    send(J); send(enc(4'h9));
    expect_out("R5 J then data", 4'b1110, 1'b0, 1'b1);
    send(enc(4'h9));
    expect_out("R5 hunting again", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_bad_in_frame();
    open_frame();
    send(enc(4'hA)); expect_out("R6 data before error", 4'hA, 1'b1, 1'b0);
    send(H);
    n_checks++;
    if (rx_dv !== 1'b1 || rx_er !== 1'b1) begin
      n_fail++;
      $display("FAIL R6 invalid group: dv/er actual %b/%b expected 1/1", rx_dv, rx_er);
    end
    send(J);
    n_checks++;
    if (rx_dv !== 1'b1 || rx_er !== 1'b1) begin
      n_fail++;
      $display("FAIL R6 stray J: dv/er actual %b/%b expected 1/1", rx_dv, rx_er);
    end
    send(enc(4'h5)); expect_out("R6 frame continues", 4'h5, 1'b1, 1'b0);
    send(T); send(R);
  endtask

  task automatic t_idle_mid();
    open_frame();
    send(enc(4'h1)); expect_out("R7 data before idle", 4'h1, 1'b1, 1'b0);
    send(I);         expect_out("R7 idle in frame", 4'h0, 1'b0, 1'b1);
    send(enc(4'h2)); expect_out("R7 frame closed", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    open_frame();
    send(enc(4'hC)); expect_out("R8 before hold", 4'hC, 1'b1, 1'b0);
    cg_in = I;
    repeat (3) @(negedge clk);
    cg_in = H;
    repeat (3) @(negedge clk);
    expect_out("R8 held with enable low", 4'hC, 1'b1, 1'b0);
    send(T); send(R);
  endtask

  task automatic t_bad_end();
    open_frame();
    send(enc(4'h6)); send(T);
    expect_out("R9 T slot", 4'h0, 1'b0, 1'b0);
    send(enc(4'h6)); expect_out("R9 T without R", 4'h0, 1'b0, 1'b1);
    send(enc(4'h6)); expect_out("R9 hunting again", 4'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cg_en = 1'b0; cg_in = 5'b11111;
    @(negedge clk);
    t_reset();
    t_hunt_ignore();
    t_good_frame();
    t_bad_ssd();
    t_bad_in_frame();
    t_idle_mid();
    t_hold();
    t_bad_end();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule